// File: doc/BRIEF.md
# Next Fetch Address Unit

A purely combinational unit that decides where instruction fetch goes next. It takes the current fetch address, the decoded major opcode and, for register-format words, the function code. It also takes the two source register values, the destination register index, the 16-bit branch offset and the 26-bit jump index. It returns the next fetch address, plus a link-write request (enable, register index, value) for the register file and a flag that marks a register-indirect target that is not word aligned.

Four kinds of flow are covered. Sequential flow steps by one word. Conditional branches are relative to the following word and take a word-scaled offset. Region jumps keep the top bits of the following word's address. Register-indirect jumps can optionally link. The unit sits between decode and the fetch address register; delay-slot handling and the fetch itself belong to neighbouring blocks.

Top module: `npc_unit`

## Requirements
- R1: When no transfer is taken (any opcode other than 0, 2 to 7; opcode 0 with function code other than 8 or 9; or a branch whose condition is false), next_pc_o equals pc_i + 4.
- R2: Opcode 2 and opcode 3 set next_pc_o to {(pc_i+4)[31:28], jidx_i, 2'b00}.
- R3: A taken branch sets next_pc_o to pc_i + 4 + the sign extension of {off_i, 2'b00} from 18 bits.
- R4: Opcode 4 is taken when rs_val_i equals rt_val_i; opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when rs_val_i, read as signed, is at most zero; opcode 7 is taken when it is above zero.
- R6: Opcode 3 raises link_we_o with link_idx_o = 31. Whenever link_we_o is high, link_val_o equals pc_i + 8.
- R7: Opcode 0 with function code 8 sets next_pc_o to rs_val_i when rs_val_i[1:0] is 0, and writes no link.
- R8: Opcode 0 with function code 9 and an aligned rs_val_i sets next_pc_o to rs_val_i and links into rd_idx_i. The target is the rs_val_i presented, even when rd_idx_i names the same register.
- R9: For function codes 8 and 9 under opcode 0, rs_val_i[1:0] != 0 raises misalign_o, holds next_pc_o at pc_i + 4 and suppresses the link write. misalign_o is low in every other case.
- R10: link_we_o is never high with link_idx_o = 0. A register-indirect link naming register 0 writes nothing.
- R11: link_we_o is high only for opcode 3 and opcode 0 with function code 9. Whenever it is low, link_idx_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current fetch address |
| opcode_i | input | 6 | Major opcode |
| funct_i | input | 6 | Function code for opcode 0 |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| rd_idx_i | input | 5 | Destination register index for the indirect link |
| off_i | input | 16 | Branch word offset |
| jidx_i | input | 26 | Region jump word index |
| next_pc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Link write request |
| link_idx_o | output | 5 | Link destination register |
| link_val_o | output | 32 | Return address to write |
| misalign_o | output | 1 | Indirect target not word aligned |

## Verification
The indirect jump with link resolves a target and a register write in the same evaluation, and alignment decides both together. Random and directed stimulus applies the linking indirect jump with misaligned targets, with register 0 as destination, and with rd equal to the source register. Each result is judged on the address, the enable and the index at once: an aligned target must move fetch and link, a misaligned one must do neither and flag, and register 0 must move fetch without linking.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OP_JMPL    = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE     = 6'd5;
  localparam logic [OP_W-1:0] OP_BLEZ    = 6'd6;
  localparam logic [OP_W-1:0] OP_BGTZ    = 6'd7;

  localparam logic [OP_W-1:0] FN_JREG    = 6'd8;
  localparam logic [OP_W-1:0] FN_JREGL   = 6'd9;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_REG = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic            take_o
);
  logic eq, rs_neg, rs_zero;

  assign eq      = (rs_val_i == rt_val_i);
  assign rs_neg  = rs_val_i[XLEN-1];
  assign rs_zero = (rs_val_i == '0);

  always_comb begin
    unique case (opcode_i)
      OP_BEQ:  take_o = eq;
      OP_BNE:  take_o = !eq;
      OP_BLEZ: take_o = rs_neg || rs_zero;
      OP_BGTZ: take_o = !rs_neg && !rs_zero;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [OP_W-1:0]  funct_i,
  input  logic             take_i,
  input  logic [1:0]       rs_low_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output npc_sel_e         sel_o,
  output logic             misalign_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o
);
  localparam logic [IDX_W-1:0] LINK_REG = {IDX_W{1'b1}};

  logic is_ind, is_indl, bad_low;

  assign is_ind  = (opcode_i == OP_SPECIAL) &&
                   ((funct_i == FN_JREG) || (funct_i == FN_JREGL));
  assign is_indl = (opcode_i == OP_SPECIAL) && (funct_i == FN_JREGL);
  assign bad_low = (rs_low_i != 2'b00);

  always_comb begin
    sel_o      = SEL_SEQ;
    misalign_o = 1'b0;
    link_we_o  = 1'b0;
    link_idx_o = '0;
    if (opcode_i == OP_JMP || opcode_i == OP_JMPL) begin
      sel_o = SEL_JMP;
      if (opcode_i == OP_JMPL) begin
        link_we_o  = 1'b1;
        link_idx_o = LINK_REG;
      end
    end else if (take_i) begin
      sel_o = SEL_BR;
    end else if (is_ind) begin
      if (bad_low) begin
        misalign_o = 1'b1;
      end else begin
        sel_o = SEL_REG;
        if (is_indl && rd_idx_i != '0) begin
          link_we_o  = 1'b1;
          link_idx_o = rd_idx_i;
        end
      end
    end
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  npc_sel_e          sel_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   link_val_o
);
  localparam int REGION_W = XLEN - JIDX_W - 2;
  localparam int EXT_W    = XLEN - OFF_W - 2;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, br_disp;

  assign seq_pc     = pc_i + WORD;
  assign link_val_o = seq_pc + WORD;
  assign br_disp    = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign br_pc      = seq_pc + br_disp;
  assign jmp_pc     = {seq_pc[XLEN-1 -: REGION_W], jidx_i, 2'b00};

  always_comb begin
    unique case (sel_i)
      SEL_BR:  next_pc_o = br_pc;
      SEL_JMP: next_pc_o = jmp_pc;
      SEL_REG: next_pc_o = rs_val_i;
      default: next_pc_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [OP_W-1:0]   funct_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [IDX_W-1:0]  link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              misalign_o
);
  localparam int REGION_W = XLEN - JIDX_W - 2;

  logic     take;
  npc_sel_e sel;

  npc_cond #(.XLEN(XLEN)) i_cond (
    .opcode_i (opcode_i),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .take_o   (take)
  );

  npc_ctrl #(.IDX_W(IDX_W)) i_ctrl (
    .opcode_i   (opcode_i),
    .funct_i    (funct_i),
    .take_i     (take),
    .rs_low_i   (rs_val_i[1:0]),
    .rd_idx_i   (rd_idx_i),
    .sel_o      (sel),
    .misalign_o (misalign_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) i_target (
    .pc_i       (pc_i),
    .rs_val_i   (rs_val_i),
    .off_i      (off_i),
    .jidx_i     (jidx_i),
    .sel_i      (sel),
    .next_pc_o  (next_pc_o),
    .link_val_o (link_val_o)
  );

  logic [XLEN-1:0] pc_plus4;
  assign pc_plus4 = pc_i + XLEN'(4);

  always_comb begin
    if (misalign_o)
      assert_misalign_hold_R9: assert (next_pc_o == pc_plus4 && !link_we_o);
    if (link_we_o)
      assert_link_nonzero_R10: assert (link_idx_o != '0);
    if (link_we_o)
      assert_link_value_R6: assert (link_val_o == pc_plus4 + XLEN'(4));
    if (link_we_o)
      assert_link_source_R11: assert (opcode_i == OP_JMPL ||
                                      (opcode_i == OP_SPECIAL && funct_i == FN_JREGL));
    if (opcode_i == OP_JMP || opcode_i == OP_JMPL)
      assert_jump_region_R2: assert (next_pc_o[XLEN-1 -: REGION_W] == pc_plus4[XLEN-1 -: REGION_W]
                                     && next_pc_o[1:0] == 2'b00);
  end
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc, rs_val, rt_val;
  logic [5:0]  opcode, funct;
  logic [4:0]  rd_idx;
  logic [15:0] off;
  logic [25:0] jidx;
  logic [31:0] next_pc, link_val;
  logic        link_we, misalign;
  logic [4:0]  link_idx;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  npc_unit i_npc_unit (
    .pc_i(pc), .opcode_i(opcode), .funct_i(funct), .rs_val_i(rs_val),
    .rt_val_i(rt_val), .rd_idx_i(rd_idx), .off_i(off), .jidx_i(jidx),
    .next_pc_o(next_pc), .link_we_o(link_we), .link_idx_o(link_idx),
    .link_val_o(link_val), .misalign_o(misalign)
  );

  function automatic string tag_of(logic [5:0] op, logic [5:0] fn, logic [31:0] rs);
    if (op == 6'd2) return "R2";
    if (op == 6'd3) return "R6";
    if (op == 6'd4 || op == 6'd5) return "R4";
    if (op == 6'd6 || op == 6'd7) return "R5";
    if (op == 6'd0 && (fn == 6'd8 || fn == 6'd9) && rs[1:0] != 2'b00) return "R9";
    if (op == 6'd0 && fn == 6'd8) return "R7";
    if (op == 6'd0 && fn == 6'd9) return "R8";
    return "R1";
  endfunction

  task automatic expect_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply_and_check();
    logic [31:0] seq, exp_pc;
    logic        exp_we, exp_mis, taken;
    logic [4:0]  exp_idx;
    string       tg;
    @(negedge clk);
    seq = pc + 32'd4;
    exp_pc = seq; exp_we = 1'b0; exp_mis = 1'b0; exp_idx = 5'd0; taken = 1'b0;
    case (opcode)
      6'd2, 6'd3: begin
        exp_pc = {seq[31:28], jidx, 2'b00};
        if (opcode == 6'd3) begin exp_we = 1'b1; exp_idx = 5'd31; end
      end
      6'd4: taken = (rs_val == rt_val);
      6'd5: taken = (rs_val != rt_val);
      6'd6: taken = ($signed(rs_val) <= 0);
      6'd7: taken = ($signed(rs_val) > 0);
      6'd0: if (funct == 6'd8 || funct == 6'd9) begin
        if (rs_val[1:0] != 2'b00) exp_mis = 1'b1;
        else begin
          exp_pc = rs_val;
          if (funct == 6'd9 && rd_idx != 5'd0) begin exp_we = 1'b1; exp_idx = rd_idx; end
        end
      end
      default: ;
    endcase
    if (taken) exp_pc = seq + {{14{off[15]}}, off, 2'b00};  // R3
    tg = taken ? "R3" : tag_of(opcode, funct, rs_val);
    @(posedge clk); #2;
    expect_val(tg, "next_pc", next_pc, exp_pc);
    expect_val(tg, "misalign", {31'd0, misalign}, {31'd0, exp_mis});
    expect_val(tg == "R8" && rd_idx == 5'd0 ? "R10" : tg, "link_we", {31'd0, link_we}, {31'd0, exp_we});
    expect_val("R11", "link_idx", {27'd0, link_idx}, {27'd0, exp_idx});
    if (exp_we) expect_val("R6", "link_val", link_val, pc + 32'd8);
  endtask

  task automatic drive(logic [5:0] op, logic [5:0] fn, logic [31:0] p, logic [31:0] a,
                       logic [31:0] b, logic [4:0] d, logic [15:0] o, logic [25:0] j);
    opcode = op; funct = fn; pc = p; rs_val = a; rt_val = b; rd_idx = d; off = o; jidx = j;
    apply_and_check();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1f2e3d4c);
    opcode = '0; funct = '0; pc = '0; rs_val = '0; rt_val = '0; rd_idx = '0; off = '0; jidx = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // reset state, R1
    apply_and_check();
    // directed corners
    drive(6'd2, 6'd0, 32'hAFFF_FFFC, 0, 0, 0, 0, 26'h3FF_FFFF);       // R2 region from pc+4
    drive(6'd3, 6'd0, 32'h1234_5678, 0, 0, 0, 0, 26'h000_0001);        // R6 jal link
    drive(6'd4, 6'd0, 32'h0000_1000, 5, 5, 0, 16'h8000, 0);            // R3 most negative offset
    drive(6'd5, 6'd0, 32'h0000_1000, 5, 5, 0, 16'h7FFF, 0);            // R4 not taken
    drive(6'd6, 6'd0, 32'h0000_2000, 32'h8000_0000, 0, 0, 16'h0010, 0);// R5 negative
    drive(6'd6, 6'd0, 32'h0000_2000, 32'h0, 0, 0, 16'h0010, 0);        // R5 zero
    drive(6'd7, 6'd0, 32'h0000_2000, 32'h0, 0, 0, 16'h0010, 0);        // R5 zero not taken
    drive(6'd7, 6'd0, 32'h0000_2000, 32'h7FFF_FFFF, 0, 0, 16'hFFFF, 0);// R5 positive
    drive(6'd0, 6'd8, 32'h0000_3000, 32'h0040_0100, 0, 7, 0, 0);       // R7
    drive(6'd0, 6'd9, 32'h0000_3000, 32'h0040_0200, 0, 31, 0, 0);      // R8 short form
    drive(6'd0, 6'd9, 32'h0000_3000, 32'h0040_0300, 0, 12, 0, 0);      // R8 rd = rs
    drive(6'd0, 6'd9, 32'h0000_3000, 32'h0040_0400, 0, 0, 0, 0);       // R10 rd 0
    drive(6'd0, 6'd9, 32'h0000_3000, 32'h0040_0402, 0, 31, 0, 0);      // R9 link suppressed
    drive(6'd0, 6'd8, 32'h0000_3000, 32'h0040_0401, 0, 31, 0, 0);      // R9
    drive(6'd0, 6'd32, 32'h0000_3000, 32'h0040_0401, 0, 31, 0, 0);     // R1 other funct
    drive(6'd35, 6'd9, 32'h0000_3000, 32'h0040_0401, 0, 31, 0, 0);     // R1 other opcode
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [5:0]  op, fn;
      logic [31:0] a, b;
      case ($urandom_range(0, 9))
        0: op = 6'd0; 1: op = 6'd2; 2: op = 6'd3; 3: op = 6'd4; 4: op = 6'd5;
        5: op = 6'd6; 6: op = 6'd7; 7: op = 6'd0; 8: op = 6'd0;
        default: op = 6'($urandom);
      endcase
      fn = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'(8 + $urandom_range(0, 1));
      case ($urandom_range(0, 4))
        0: a = 32'd0;
        1: a = 32'h8000_0000 | $urandom;
        2: a = $urandom & 32'hFFFF_FFFC;
        default: a = $urandom;
      endcase
      b = ($urandom_range(0, 2) == 0) ? a : $urandom;
      drive(op, fn, $urandom & 32'hFFFF_FFFC, a, b, 5'($urandom), 16'($urandom), 26'($urandom));
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule